// File: doc/BRIEF.md
# Request Ingress Delay Stage with Texture Bypass

This block is the entry stage of a memory slice. Every request offered by the network either goes straight into the queue that feeds the slice cache or waits in a first-in first-out holding queue for a fixed number of cycles. The payload is opaque to the block. A single flag marks the request as a texture access. Texture requests skip the wait. All other requests are stamped, on arrival, with a due time: the value of a free-running 32-bit cycle counter plus the configured latency.

Each cycle the block looks at the oldest held request. It releases that request into the cache queue when the counter has reached the request's due time and the cache queue reports room. At most one held request leaves per cycle, and they leave in arrival order. A texture bypass takes priority over a release in the same cycle. The network sees a full indication that follows the cache queue's full input and nothing else. The holding queue has a full flag of its own. A non-texture request offered while that flag is set is refused through the accept output.

Top module: `req_ingress_delay`

## Requirements
- R1: An offered request with in_tex=1 while dst_full=0 is accepted (in_accept=1) and appears in the same cycle on dst_push=1 with dst_tex=1 and dst_data equal to in_data. When dst_full=1, a texture request is refused (in_accept=0).
- R2: An offered request with in_tex=0 while dly_full=0 is accepted and held. It does not appear at the output in its arrival cycle.
- R3: A held request never leaves earlier than LATENCY cycles after its arrival cycle, and never earlier than the cycle after arrival.
- R4: A held request leaves in exactly the first cycle allowed by R3, provided that the cache queue is not full, no bypass occurs in that cycle and no older request is still waiting. It leaves with dst_tex=0 and its original payload.
- R5: Held requests leave in arrival order, at most one per cycle.
- R6: dst_push is never asserted while dst_full=1. A held request stays held until dst_full falls.
- R7: When a texture bypass and a matured release compete in the same cycle, the bypass is pushed. The release follows in the next free cycle.
- R8: up_full equals dst_full in every cycle, independent of the holding queue.
- R9: dly_full is set exactly when DEPTH requests are held. A non-texture request offered while it is set is refused and never appears at the output.
- R10: Due-time comparison uses a wrap-safe difference, so requests stamped before the 32-bit counter wraps are released on time after it wraps.
- R11: After reset the holding queue is empty: dly_full=0 and no held request is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is offered this cycle |
| in_tex | input | 1 | Offered request is a texture access |
| in_data | input | W | Opaque request payload |
| dst_full | input | 1 | Cache queue cannot take a push this cycle |
| in_accept | output | 1 | Offered request is taken this cycle |
| up_full | output | 1 | Full indication to the network |
| dly_full | output | 1 | Holding queue is full |
| dst_push | output | 1 | Push into the cache queue |
| dst_tex | output | 1 | Pushed request came through the bypass |
| dst_data | output | W | Pushed request payload |

## Verification
A corrupted holding-queue pointer or count shows at the ports within one release. The payload at dst_data breaks arrival order, or dly_full rises or falls at an occupancy other than DEPTH. A wrong due stamp or a faulty comparison shows in the cycle the oldest request should mature: dst_push is either missing in that cycle or appears earlier. Across the counter wrap, a comparison that is not wrap-safe makes requests stall or leave at once. An arbitration fault shows as a push during dst_full, or as a lost release in the cycle after a bypass collision.

// File: rtl/rid_pkg.sv
package rid_pkg;

    localparam int unsigned TS_W = 32;

    typedef logic [TS_W-1:0] stamp_t;

    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_HELD   = 2'd2
    } out_src_e;

    // Wrap-safe maturity test: the signed distance now - due is non-negative.
    function automatic logic stamp_reached(input stamp_t now, input stamp_t due);
        stamp_t diff;
        diff = now - due;
        return ~diff[TS_W-1];
    endfunction

endpackage

// File: rtl/rid_cycle_counter.sv
module rid_cycle_counter
    import rid_pkg::*;
#(
    parameter stamp_t START = '0
) (
    input  logic   clk,
    input  logic   rst,
    output stamp_t now
);
    always_ff @(posedge clk) begin
        if (rst) now <= START;
        else     now <= now + stamp_t'(1);
    end
endmodule

// File: rtl/rid_hold_fifo.sv
module rid_hold_fifo
    import rid_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  stamp_t       push_due,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output stamp_t       head_due,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [W-1:0] data;
        stamp_t       due;
    } slot_t;

    slot_t           mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   count;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + AW'(1);
    endfunction

    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign head_data = mem[rd_ptr].data;
    assign head_due  = mem[rd_ptr].due;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= '{data: push_data, due: push_due};
    end
endmodule

// File: rtl/rid_route.sv
module rid_route
    import rid_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         in_valid,
    input  logic         in_tex,
    input  logic [W-1:0] in_data,
    input  logic         dst_full,
    input  stamp_t       now,
    input  logic         q_empty,
    input  logic         q_full,
    input  logic [W-1:0] q_head_data,
    input  stamp_t       q_head_due,
    output logic         q_push,
    output logic         q_pop,
    output logic         in_accept,
    output logic         dst_push,
    output logic         dst_tex,
    output logic [W-1:0] dst_data
);
    out_src_e src;
    logic     bypass;
    logic     matured;

    assign bypass  = in_valid & in_tex & ~dst_full;
    assign matured = ~q_empty & stamp_reached(now, q_head_due);

    always_comb begin
        if (bypass)                     src = SRC_BYPASS;
        else if (matured && !dst_full)  src = SRC_HELD;
        else                            src = SRC_IDLE;
    end

    assign q_push    = in_valid & ~in_tex & ~q_full;
    assign q_pop     = (src == SRC_HELD);
    assign in_accept = bypass | q_push;
    assign dst_push  = (src != SRC_IDLE);
    assign dst_tex   = (src == SRC_BYPASS);
    assign dst_data  = (src == SRC_BYPASS) ? in_data : q_head_data;
endmodule

// File: rtl/req_ingress_delay.sv
module req_ingress_delay
    import rid_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned LATENCY = 4,
    parameter stamp_t      START   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_tex,
    input  logic [W-1:0] in_data,
    input  logic         dst_full,
    output logic         in_accept,
    output logic         up_full,
    output logic         dly_full,
    output logic         dst_push,
    output logic         dst_tex,
    output logic [W-1:0] dst_data
);
    localparam stamp_t LAT_STAMP = stamp_t'(LATENCY);

    stamp_t       now;
    stamp_t       due_in;
    stamp_t       head_due;
    logic [W-1:0] head_data;
    logic         q_empty;
    logic         q_full;
    logic         q_push;
    logic         q_pop;

    assign due_in   = now + LAT_STAMP;
    assign up_full  = dst_full;
    assign dly_full = q_full;

    rid_cycle_counter #(.START(START)) u_cnt (
        .clk (clk),
        .rst (rst),
        .now (now)
    );

    rid_hold_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_data (in_data),
        .push_due  (due_in),
        .pop       (q_pop),
        .head_data (head_data),
        .head_due  (head_due),
        .empty     (q_empty),
        .full      (q_full)
    );

    rid_route #(.W(W)) u_route (
        .in_valid    (in_valid),
        .in_tex      (in_tex),
        .in_data     (in_data),
        .dst_full    (dst_full),
        .now         (now),
        .q_empty     (q_empty),
        .q_full      (q_full),
        .q_head_data (head_data),
        .q_head_due  (head_due),
        .q_push      (q_push),
        .q_pop       (q_pop),
        .in_accept   (in_accept),
        .dst_push    (dst_push),
        .dst_tex     (dst_tex),
        .dst_data    (dst_data)
    );
endmodule

// File: rtl/req_ingress_delay_chk.sv
module req_ingress_delay_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_tex,
    input logic [W-1:0] in_data,
    input logic         dst_full,
    input logic         in_accept,
    input logic         dly_full,
    input logic         dst_push,
    input logic         dst_tex,
    input logic [W-1:0] dst_data
);
    // R6: never push into a full cache queue
    a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        dst_full |-> !dst_push);

    // R1: texture bypass passes through in the same cycle
    a_r1_bypass_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_tex && !dst_full) |-> (dst_push && dst_tex && dst_data == in_data && in_accept));

    // R9: refusal while the holding queue is full
    a_r9_refuse_when_full: assert property (@(posedge clk) disable iff (rst)
        (dly_full && in_valid && !in_tex) |-> !in_accept);

    // R9: a full holding queue stays full until a held request leaves
    a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
        (dly_full && !(dst_push && !dst_tex)) |=> dly_full);

    // R11: holding queue empty right after reset
    a_r11_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dly_full && !(dst_push && !dst_tex)));
endmodule

bind req_ingress_delay req_ingress_delay_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_tex    (in_tex),
    .in_data   (in_data),
    .dst_full  (dst_full),
    .in_accept (in_accept),
    .dly_full  (dly_full),
    .dst_push  (dst_push),
    .dst_tex   (dst_tex),
    .dst_data  (dst_data)
);

// File: tb/req_ingress_delay_tb.sv
module req_ingress_delay_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int DEPTH      = 4;
    localparam int LAT        = 4;
    localparam logic [31:0] START = 32'hFFFF_FFF8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_tex = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         dst_full = 1'b0;
    logic         in_accept, up_full, dly_full, dst_push, dst_tex;
    logic [W-1:0] dst_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    string rtag = "R4";
    logic done = 1'b0;

    typedef struct { logic [W-1:0] data; int due; } held_t;
    held_t dq[$];

    req_ingress_delay #(.W(W), .DEPTH(DEPTH), .LATENCY(LAT), .START(START)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_tex(in_tex), .in_data(in_data),
        .dst_full(dst_full), .in_accept(in_accept), .up_full(up_full), .dly_full(dly_full),
        .dst_push(dst_push), .dst_tex(dst_tex), .dst_data(dst_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic tex, input logic [W-1:0] d, input logic full);
        @(negedge clk);
        in_valid = v; in_tex = tex; in_data = d; dst_full = full;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, 1'b0);
    endtask

    // Monitor / scoreboard
    always begin
        @(negedge clk);
        #2;
        if (!rst && !done) begin
            logic exp_dfull, bp, rel, acc;
            exp_dfull = (dq.size() == DEPTH);
            check("R9 dly_full", dly_full, exp_dfull);
            check("R8 up_full", up_full, dst_full);
            bp  = in_valid && in_tex && !dst_full;
            acc = in_valid && (in_tex ? !dst_full : !exp_dfull);
            check(in_tex ? "R1 accept" : "R2 R9 accept", in_accept, acc);
            rel = !bp && !dst_full && dq.size() > 0 && dq[0].due <= cyc;
            check({rtag, " R3 R6 R7 push"}, dst_push, bp || rel);
            if (bp) begin
                check("R1 tex", dst_tex, 1'b1);
                check("R1 data", dst_data, in_data);
            end else if (rel) begin
                check({rtag, " tex"}, dst_tex, 1'b0);
                check({rtag, " R5 data"}, dst_data, dq[0].data);
                void'(dq.pop_front());
            end
            if (acc && !in_tex) dq.push_back('{data: in_data, due: cyc + ((LAT == 0) ? 1 : LAT)});
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        #1;
        check("R11 dly_full", dly_full, 1'b0);
        check("R11 dst_push", dst_push, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        // R10: stamps straddle the counter wrap
        rtag = "R10";
        drive(1, 0, 8'h11, 0);
        drive(1, 0, 8'h12, 0);
        drive(1, 0, 8'h13, 0);
        idle(4);
        drive(1, 0, 8'h14, 0);
        idle(12);
        rtag = "R4";
        drive(1, 0, 8'h21, 0);
        idle(8);
        // R1: bypass stream, also refused while full
        drive(1, 1, 8'h31, 0);
        drive(1, 1, 8'h32, 0);
        drive(1, 1, 8'h33, 1);
        drive(1, 1, 8'h34, 0);
        idle(2);
        // R7: collision at maturity
        rtag = "R7";
        drive(1, 0, 8'h41, 0);
        idle(LAT - 1);
        drive(1, 1, 8'h42, 0);
        idle(4);
        // R6: stall behind dst_full
        rtag = "R6";
        drive(1, 0, 8'h51, 0);
        drive(1, 0, 8'h52, 0);
        for (int i = 0; i < 10; i++) drive(0, 0, '0, 1);
        idle(6);
        // R9: overfill the holding queue
        rtag = "R9";
        for (int i = 0; i < DEPTH + 2; i++) drive(1, 0, W'(8'h60 + i), 0);
        idle(20);
        // R5: mixed traffic
        rtag = "R5";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0], lfsr[1] & lfsr[2], lfsr[15:8], lfsr[3] & lfsr[4]);
        end
        idle(30);
        check("R5 drained", dq.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule